// File: doc/BRIEF.md
# Multi-Phase Staggered Trigger Generator

This block issues one-tick launch triggers for sixteen workers so that their activity can be spread over time instead of landing on a single clock edge. Each worker owns a phase accumulator in which the full register range is one turn. On every enabled tick the accumulator advances by one sixteenth of a turn. The worker's trigger bit pulses on the tick where its accumulator wraps past zero. With no perturbation, each worker therefore launches once every sixteen enabled ticks.

A 2-bit mode selects how the accumulators start and how fast they turn. In lockstep mode they all start at zero, so all sixteen workers fire together. In staggered mode worker k starts k slots into the turn, so exactly one worker fires per tick. Detuned mode uses the staggered start and adds a small fixed extra advance on every tick. This rotates the whole lattice slowly, so it never settles into a fixed alignment with an outside rhythm.

The mode is captured on the first clock after reset is released. The same clock loads the start phases. A perturbation vector lets a test speed up chosen workers so that they drift out of their slots. Every result is fully deterministic.

Top module: `stagger_trig_gen`

## Requirements
- R1: With no perturbation, in lockstep or staggered mode each worker fires exactly once in any 16 consecutive enabled ticks.
- R2: Mode 2'b00 (lockstep): all accumulators start at 0 and all 16 trigger bits rise together on the 16th enabled tick after the load clock, then on every 16th enabled tick after that; no bit is set on any other tick.
- R3: Mode 2'b01 (staggered): worker k starts at k·2^20 (PHASE_W=24, one turn = 2^24). Exactly one bit is set per enabled tick: worker 15 on the first enabled tick, then 14, and so on down to worker 0 on the 16th.
- R4: Mode 2'b10 (detuned): staggered start, and each accumulator advances by 2^20+320 per enabled tick. Bit k is set exactly when that addition carries out of bit 23, so at most two bits are set on any tick.
- R5: Mode 2'b11 behaves exactly as staggered mode.
- R6: While en_i is low no trigger bit is set and no accumulator moves. The firing order resumes where it stopped.
- R7: mode_i is sampled only on the first clock edge after rst_ni is released. That edge loads the start phases and produces no trigger. Later changes of mode_i have no effect until the next reset.
- R8: While pert_i[k] is high, worker k advances by an extra 4096 counts on each enabled tick.
- R9: trig_o is a registered output. A bit is high for the single cycle that follows the clock edge on which its accumulator wrapped. Reset clears all bits.
- R10: The same reset, mode and input sequence always produces the same trigger sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance all accumulators on this tick |
| mode_i | input | 2 | 00 lockstep, 01 staggered, 10 detuned, 11 as staggered; captured after reset |
| pert_i | input | 16 | Per-worker extra advance, for drift testing |
| trig_o | output | 16 | One-tick launch pulse per worker |

## Verification
The clock edge after reset release is a load edge and produces no trigger. After it, the advance made on the n-th enabled edge shows on trig_o right after that same edge, one register stage later, and stays until the next edge. The driver computes the expected vector for every edge from a phase model written from the requirements and queues it before that edge. The monitor pops each queued vector a quarter period after the edge and compares it. Idle ticks queue an all-zero vector. Per-worker fire counts and a replay of a recorded detuned run give end-to-end checks of once-per-period firing and of repeatability.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [1:0] {
    MODE_LOCK = 2'b00,
    MODE_STAG = 2'b01,
    MODE_DET  = 2'b10,
    MODE_ALT  = 2'b11
  } mode_e;

  function automatic logic is_staggered(input mode_e m);
    return m != MODE_LOCK;
  endfunction

  function automatic logic is_detuned(input mode_e m);
    return m == MODE_DET;
  endfunction

endpackage

// File: rtl/stg_ctrl.sv
module stg_ctrl
  import stg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  [1:0] mode_i,
  output logic  load_o,
  output logic  load_stag_o,
  output logic  adv_o,
  output logic  armed_o,
  output mode_e mode_o
);

  logic  armed_q;
  mode_e mode_q;

  // first edge after reset captures the mode and loads start phases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= MODE_LOCK;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      mode_q  <= mode_e'(mode_i);
    end
  end

  assign load_o      = !armed_q;
  assign load_stag_o = is_staggered(mode_e'(mode_i));
  assign adv_o       = armed_q & en_i;
  assign armed_o     = armed_q;
  assign mode_o      = mode_q;

endmodule

// File: rtl/stg_step_gen.sv
module stg_step_gen
  import stg_pkg::*;
#(
  parameter int unsigned N_WORKERS   = 16,
  parameter int unsigned PHASE_W     = 24,
  parameter int unsigned DETUNE_STEP = 320,
  parameter int unsigned PERT_STEP   = 4096
) (
  input  mode_e                              mode_i,
  input  logic [N_WORKERS-1:0]               pert_i,
  output logic [N_WORKERS-1:0][PHASE_W-1:0]  step_o
);

  localparam int unsigned SLOT_LOG = PHASE_W - $clog2(N_WORKERS);
  localparam logic [PHASE_W-1:0] SLOT_STEP = {{(PHASE_W-1){1'b0}}, 1'b1} << SLOT_LOG;
  localparam logic [PHASE_W-1:0] DET_W     = PHASE_W'(DETUNE_STEP);
  localparam logic [PHASE_W-1:0] PERT_W    = PHASE_W'(PERT_STEP);

  logic [PHASE_W-1:0] base_step;

  always_comb begin
    base_step = SLOT_STEP;
    if (is_detuned(mode_i)) base_step = SLOT_STEP + DET_W;
  end

  for (genvar k = 0; k < N_WORKERS; k++) begin : g_step
    assign step_o[k] = pert_i[k] ? base_step + PERT_W : base_step;
  end

endmodule

// File: rtl/stg_phase_cell.sv
module stg_phase_cell #(
  parameter int unsigned        PHASE_W    = 24,
  parameter logic [PHASE_W-1:0] INIT_PHASE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               stag_i,
  input  logic               adv_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic               fire_o
);

  logic [PHASE_W-1:0] acc_q;
  logic               fire_q;
  logic [PHASE_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      fire_q <= 1'b0;
    end else if (load_i) begin
      acc_q  <= stag_i ? INIT_PHASE : '0;
      fire_q <= 1'b0;
    end else if (adv_i) begin
      acc_q  <= sum[PHASE_W-1:0];
      fire_q <= sum[PHASE_W];   // carry out = wrap past zero
    end else begin
      fire_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/stagger_trig_gen.sv
module stagger_trig_gen
  import stg_pkg::*;
#(
  parameter int unsigned N_WORKERS   = 16,
  parameter int unsigned PHASE_W     = 24,
  parameter int unsigned DETUNE_STEP = 320,
  parameter int unsigned PERT_STEP   = 4096
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           mode_i,
  input  logic [N_WORKERS-1:0] pert_i,
  output logic [N_WORKERS-1:0] trig_o
);

  localparam int unsigned SLOT_LOG = PHASE_W - $clog2(N_WORKERS);

  logic  load, load_stag, adv, armed_q;
  mode_e mode_q;
  logic [N_WORKERS-1:0][PHASE_W-1:0] step;

  stg_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .load_o      (load),
    .load_stag_o (load_stag),
    .adv_o       (adv),
    .armed_o     (armed_q),
    .mode_o      (mode_q)
  );

  stg_step_gen #(
    .N_WORKERS   (N_WORKERS),
    .PHASE_W     (PHASE_W),
    .DETUNE_STEP (DETUNE_STEP),
    .PERT_STEP   (PERT_STEP)
  ) u_step (
    .mode_i (mode_q),
    .pert_i (pert_i),
    .step_o (step)
  );

  for (genvar k = 0; k < N_WORKERS; k++) begin : g_cell
    stg_phase_cell #(
      .PHASE_W    (PHASE_W),
      .INIT_PHASE (PHASE_W'(k) << SLOT_LOG)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .stag_i (load_stag),
      .adv_i  (adv),
      .step_i (step[k]),
      .fire_o (trig_o[k])
    );
  end

endmodule

// File: rtl/stagger_trig_gen_chk.sv
module stagger_trig_gen_chk
  import stg_pkg::*;
#(
  parameter int unsigned N_WORKERS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic [N_WORKERS-1:0] pert_i,
  input logic [N_WORKERS-1:0] trig_o,
  input logic                 armed_q,
  input mode_e                mode_q
);

  logic pert_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pert_seen_q <= 1'b0;
    else if (|pert_i)   pert_seen_q <= 1'b1;
  end

  // R2: lockstep fires all workers or none
  a_r2_lock_all_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOCK && !pert_seen_q) |-> (trig_o == '0 || trig_o == '1));

  // R3 / R5: staggered advance fires exactly one worker
  a_r3_one_per_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(armed_q) && (mode_q == MODE_STAG || mode_q == MODE_ALT)
     && !pert_seen_q) |-> ($countones(trig_o) == 1));

  // R4: detuned never fires more than two at once
  a_r4_det_at_most_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DET && !pert_seen_q) |-> ($countones(trig_o) <= 2));

  // R6: idle tick gives no trigger
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (trig_o == '0));

  // R7: captured mode holds once armed
  a_r7_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(armed_q) && armed_q) |-> $stable(mode_q));

  // R7: load edge produces no trigger
  a_r7_load_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> (trig_o == '0));

endmodule

bind stagger_trig_gen stagger_trig_gen_chk #(.N_WORKERS(N_WORKERS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .pert_i  (pert_i),
  .trig_o  (trig_o),
  .armed_q (armed_q),
  .mode_q  (mode_q)
);

// File: tb/stagger_trig_gen_tb_top.sv
module stagger_trig_gen_tb_top;

  localparam int CLK_P   = 10;
  localparam int NW      = 16;
  localparam int PW      = 24;
  localparam int SLOT    = 1 << 20;
  localparam int DET     = 320;
  localparam int PERT    = 4096;
  localparam int REC_LEN = 100;

  typedef struct {
    logic [NW-1:0] vec;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [NW-1:0] pert_i = '0;
  logic [NW-1:0] trig_o;

  exp_t          exp_q[$];
  logic [PW-1:0] m_acc [NW];
  logic [1:0]    m_mode;
  int            n_chk = 0;
  int            n_err = 0;
  int            fire_cnt [NW];
  logic [NW-1:0] rec [REC_LEN];
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stagger_trig_gen dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_i),
    .pert_i (pert_i),
    .trig_o (trig_o)
  );

  task automatic check(input bit ok, input string tag, input logic [NW-1:0] act,
                       input logic [NW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare queued expectation after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(trig_o === e.vec, e.tag, trig_o, e.vec);
      end
    end
  end

  // called at a negedge; mode m is sampled on the load edge (R7)
  task automatic do_reset(input logic [1:0] m);
    rst_ni = 1'b0;
    en_i   = 1'b0;
    pert_i = '0;
    mode_i = m;
    repeat (2) @(negedge clk);
    check(trig_o == '0, "R9 reset clears", trig_o, '0);
    rst_ni = 1'b1;
    m_mode = m;
    for (int k = 0; k < NW; k++) m_acc[k] = (m == 2'b00) ? '0 : PW'(k * SLOT);
    @(posedge clk);   // load edge, no trigger
    @(negedge clk);
    check(trig_o == '0, "R7 load edge quiet", trig_o, '0);
  endtask

  task automatic tick(input logic en, input logic [NW-1:0] pert, input string tag);
    logic [NW-1:0] ev;
    exp_t          it;
    en_i   = en;
    pert_i = pert;
    ev     = '0;
    if (en) begin
      for (int k = 0; k < NW; k++) begin
        logic [PW:0] s;
        int          st;
        st = SLOT + ((m_mode == 2'b10) ? DET : 0) + (pert[k] ? PERT : 0);
        s  = {1'b0, m_acc[k]} + (PW+1)'(st);
        ev[k]    = s[PW];
        m_acc[k] = s[PW-1:0];
      end
    end
    it.vec = ev;
    it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    for (int k = 0; k < NW; k++) if (trig_o[k]) fire_cnt[k]++;
  endtask

  task automatic clear_counts();
    for (int k = 0; k < NW; k++) fire_cnt[k] = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);

    // R2 lockstep, R1 once per period
    do_reset(2'b00);
    clear_counts();
    for (int i = 0; i < 48; i++) tick(1'b1, '0, "R2 lockstep burst");
    for (int k = 0; k < NW; k++)
      check(fire_cnt[k] == 3, "R1 lockstep count", NW'(fire_cnt[k]), NW'(3));

    // R3 staggered order
    do_reset(2'b01);
    clear_counts();
    for (int i = 0; i < 32; i++) tick(1'b1, '0, "R3 staggered slot");
    for (int k = 0; k < NW; k++)
      check(fire_cnt[k] == 2, "R1 staggered count", NW'(fire_cnt[k]), NW'(2));
    // R6 idle hold, then resume
    for (int i = 0; i < 5; i++) tick(1'b0, '0, "R6 idle quiet");
    for (int i = 0; i < 16; i++) begin
      tick(1'b1, '0, "R6 resume order");
      if (i % 3 == 0) tick(1'b0, '0, "R6 gap quiet");
    end
    // R7 mode change ignored without reset
    mode_i = 2'b00;
    for (int i = 0; i < 20; i++) tick(1'b1, '0, "R7 mode change ignored");

    // R5 reserved code as staggered
    do_reset(2'b11);
    for (int i = 0; i < 32; i++) tick(1'b1, '0, "R5 code 11 staggered");

    // R4 detuned, long enough for the lattice to slip a slot
    do_reset(2'b10);
    for (int i = 0; i < 4000; i++) tick(1'b1, '0, "R4 detuned wrap");

    // R8 perturbation on worker 3
    do_reset(2'b01);
    for (int i = 0; i < 300; i++) tick(1'b1, NW'(16'h0008), "R8 perturbed worker");
    for (int i = 0; i < 50; i++) tick(1'b1, '0, "R8 after perturbation");

    // R10 repeatability: record then replay
    do_reset(2'b10);
    for (int i = 0; i < REC_LEN; i++) begin
      tick(1'b1, (i % 7 == 0) ? NW'(16'h0101) : '0, "R10 first run");
      rec[i] = trig_o;
    end
    do_reset(2'b10);
    for (int i = 0; i < REC_LEN; i++) begin
      tick(1'b1, (i % 7 == 0) ? NW'(16'h0101) : '0, "R10 second run");
      check(trig_o === rec[i], "R10 replay match", trig_o, rec[i]);
    end

    en_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule